// File: doc/BRIEF.md
# Paged Audio DMA Controller Register File

This block is the host-facing register bank of a three-channel audio DMA controller. Two of the channels play audio out and one captures audio in. The host reaches the bank through a synchronous 32-bit port that uses an 8-bit byte offset. The bank holds a control word, a fixed status word, a codec word, a serial-control word and a 4-bit page selector. It also holds the per-channel sample-count, frame-address and frame-count registers. All of these values are presented to the data-movement engine as plain outputs.

Offsets 0x30 through 0x3F form a paged window. When the host offset falls inside that window, the page selector is prepended to the offset, which gives a 12-bit internal address. Every other offset is used with a zero page. The frame registers live at internal addresses in that paged space. Two slots in the paged space are unpopulated: they ignore writes and read back as all ones, and so does every offset that decodes to nothing.

The data-movement engine writes back a channel's running sample count (upper half) and its 2-bit leftover-byte counter through a small update port. From the control and serial-control words, the block derives one run-enable per channel.

Top module: `apc_regfile`

## Requirements
- R1: After reset, control reads 0x00000001, status reads 0x00000060, and page, codec, serial control, every sample count, frame address, frame count and leftover counter read 0. The outputs rvalid and rdata are 0.
- R2: A read strobe at a clock edge raises rvalid for exactly the following cycle, with rdata holding the addressed value. That value is the state before any write made in the same cycle.
- R3: A write to offset 0x0C stores wdata[3:0] as the page. Reading offset 0x0C returns that page zero-extended.
- R4: Offsets 0x00 (control), 0x10 (codec) and 0x20 (serial control) are full 32-bit read/write. Offset 0x04 (status) always reads 0x00000060 and ignores writes.
- R5: For an offset o in 0x30..0x3F, the internal address is {page, o}. Frame address and frame count are at 0xC30/0xC34 for playback 1, 0xC38/0xC3C for playback 2 and 0xD30/0xD34 for capture, each read/write. Outside the window the page has no effect.
- R6: Internal addresses 0xD38 and 0xD3C ignore writes and read 0xFFFFFFFF. Any other offset that decodes to nothing also reads 0xFFFFFFFF, including window offsets with an unused page and offsets that are not 4-byte aligned.
- R7: The sample counts are at 0x24 (playback 1), 0x28 (playback 2) and 0x2C (capture). A host write replaces bits 15:0 and keeps bits 31:16.
- R8: A host write to a channel's frame count clears that channel's leftover counter. This takes priority over an engine update in the same cycle.
- R9: When eng_we[c] is high, channel c loads eng_hi into sample-count bits 31:16 and eng_lo into its leftover counter. A same-cycle host write still sets bits 15:0.
- R10: run_en[0] = control[6] & ~sctl[11]; run_en[1] = control[5] & ~sctl[12]; run_en[2] = control[4]. The capture channel ignores every serial-control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host byte offset |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| eng_we | input | 3 | Engine update strobe per channel |
| eng_hi | input | 48 | Engine running sample count per channel (16 bits each) |
| eng_lo | input | 6 | Engine leftover-byte count per channel (2 bits each) |
| ctrl_q | output | 32 | Control word |
| sctl_q | output | 32 | Serial-control word |
| page_q | output | 4 | Page selector |
| scount_o | output | 96 | Sample counts, channel c at bits [32c+31:32c] |
| fadr_o | output | 96 | Frame addresses, channel c at bits [32c+31:32c] |
| fcnt_o | output | 96 | Frame counts, channel c at bits [32c+31:32c] |
| leftover_o | output | 6 | Leftover counters, channel c at bits [2c+1:2c] |
| run_en | output | 3 | Run enable per channel |

## Verification
The assertions assume that rd_en and wr_en are held low while reset is active. The sample-count property assumes that no engine update for playback 1 happens in the same cycle as the host write it checks, and it excludes such cycles explicitly. The stimulus releases reset with both strobes low. It then mixes directed accesses with pseudo-random accesses drawn from a pool of decoded, phantom, misaligned and unpaged offsets, with page values biased toward the two populated pages. Engine updates are sometimes issued in the same cycle as frame-count writes, to exercise the priority rule.

// File: rtl/apc_pkg.sv
package apc_pkg;
   localparam int APC_NCH   = 3;
   localparam int APC_IW    = 12;

   localparam logic [11:0] OFS_CTRL  = 12'h000;
   localparam logic [11:0] OFS_STAT  = 12'h004;
   localparam logic [11:0] OFS_PAGE  = 12'h00C;
   localparam logic [11:0] OFS_CODEC = 12'h010;
   localparam logic [11:0] OFS_SCTL  = 12'h020;
   localparam logic [11:0] OFS_SCNT0 = 12'h024;

   localparam logic [7:0]  WIN_LO    = 8'h30;
   localparam logic [7:0]  WIN_HI    = 8'h3F;

   localparam logic [31:0] CTRL_RST  = 32'h0000_0001;
   localparam logic [31:0] STAT_VAL  = 32'h0000_0060;

   typedef struct packed {
      logic ctrl;
      logic stat;
      logic page;
      logic codec;
      logic sctl;
   } fixed_sel_t;

   function automatic logic [11:0] scnt_ofs(input int ch);
      return OFS_SCNT0 + 12'(4 * ch);
   endfunction

   function automatic logic [11:0] fadr_ofs(input int ch);
      return (ch < 2) ? (12'hC30 + 12'(8 * ch)) : 12'hD30;
   endfunction

   function automatic logic [11:0] fcnt_ofs(input int ch);
      return fadr_ofs(ch) + 12'h004;
   endfunction

   function automatic int en_bit(input int ch);
      return 6 - ch;
   endfunction

   function automatic int pause_bit(input int ch);
      return 11 + ch;
   endfunction

   function automatic bit has_pause(input int ch);
      return ch < 2;
   endfunction
endpackage

// File: rtl/apc_addr_map.sv
module apc_addr_map
   import apc_pkg::*;
#(
   parameter int AW  = 8,
   parameter int PW  = 4,
   parameter int NCH = APC_NCH,
   localparam int IW = AW + PW
) (
   input  logic [AW-1:0]  addr,
   input  logic [PW-1:0]  page,
   output logic [IW-1:0]  iaddr,
   output fixed_sel_t     fsel,
   output logic [NCH-1:0] s_scnt,
   output logic [NCH-1:0] s_fadr,
   output logic [NCH-1:0] s_fcnt
);
   if (IW != APC_IW) begin : g_bad_iw
      $error("apc_addr_map: internal address must be %0d bits", APC_IW);
   end

   logic in_win;

   always_comb begin
      in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
      iaddr  = in_win ? {page, addr} : {{PW{1'b0}}, addr};
   end

   always_comb begin
      fsel.ctrl  = (iaddr == OFS_CTRL);
      fsel.stat  = (iaddr == OFS_STAT);
      fsel.page  = (iaddr == OFS_PAGE);
      fsel.codec = (iaddr == OFS_CODEC);
      fsel.sctl  = (iaddr == OFS_SCTL);
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign s_scnt[c] = (iaddr == scnt_ofs(c));
      assign s_fadr[c] = (iaddr == fadr_ofs(c));
      assign s_fcnt[c] = (iaddr == fcnt_ofs(c));
   end
endmodule

// File: rtl/apc_chan_regs.sv
module apc_chan_regs #(
   parameter int DW = 32,
   parameter int HW = 16,
   parameter int LW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_scnt,
   input  logic          wr_fadr,
   input  logic          wr_fcnt,
   input  logic [DW-1:0] wdata,
   input  logic          eng_we,
   input  logic [DW-HW-1:0] eng_hi,
   input  logic [LW-1:0] eng_lo,
   output logic [DW-1:0] scount,
   output logic [DW-1:0] fadr,
   output logic [DW-1:0] fcnt,
   output logic [LW-1:0] leftover
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scount <= '0;
      end else begin
         if (eng_we)  scount[DW-1:HW] <= eng_hi;
         if (wr_scnt) scount[HW-1:0]  <= wdata[HW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fadr <= '0;
         fcnt <= '0;
      end else begin
         if (wr_fadr) fadr <= wdata;
         if (wr_fcnt) fcnt <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       leftover <= '0;
      else if (wr_fcnt) leftover <= '0;
      else if (eng_we)  leftover <= eng_lo;
   end
endmodule

// File: rtl/apc_regfile.sv
module apc_regfile
   import apc_pkg::*;
#(
   parameter int DW  = 32,
   parameter int AW  = 8,
   parameter int PW  = 4,
   parameter int HW  = 16,
   parameter int LW  = 2,
   localparam int NCH = APC_NCH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic              rvalid,
   input  logic [NCH-1:0]    eng_we,
   input  logic [NCH*(DW-HW)-1:0] eng_hi,
   input  logic [NCH*LW-1:0] eng_lo,
   output logic [DW-1:0]     ctrl_q,
   output logic [DW-1:0]     sctl_q,
   output logic [PW-1:0]     page_q,
   output logic [NCH*DW-1:0] scount_o,
   output logic [NCH*DW-1:0] fadr_o,
   output logic [NCH*DW-1:0] fcnt_o,
   output logic [NCH*LW-1:0] leftover_o,
   output logic [NCH-1:0]    run_en
);
   if (DW != 32 || AW != 8 || PW != 4 || 2 * HW != DW) begin : g_bad_cfg
      $error("apc_regfile: unsupported width configuration");
   end

   logic [DW-1:0]  codec_r;
   logic [AW+PW-1:0] iaddr;
   fixed_sel_t     fsel;
   logic [NCH-1:0] s_scnt, s_fadr, s_fcnt;
   logic [DW-1:0]  rd_mux;

   apc_addr_map #(.AW(AW), .PW(PW), .NCH(NCH)) u_map (
      .addr   (addr),
      .page   (page_q),
      .iaddr  (iaddr),
      .fsel   (fsel),
      .s_scnt (s_scnt),
      .s_fadr (s_fadr),
      .s_fcnt (s_fcnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST;
         sctl_q  <= '0;
         codec_r <= '0;
         page_q  <= '0;
      end else if (wr_en) begin
         if (fsel.ctrl)  ctrl_q  <= wdata;
         if (fsel.sctl)  sctl_q  <= wdata;
         if (fsel.codec) codec_r <= wdata;
         if (fsel.page)  page_q  <= wdata[PW-1:0];
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      apc_chan_regs #(.DW(DW), .HW(HW), .LW(LW)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_scnt  (wr_en && s_scnt[c]),
         .wr_fadr  (wr_en && s_fadr[c]),
         .wr_fcnt  (wr_en && s_fcnt[c]),
         .wdata    (wdata),
         .eng_we   (eng_we[c]),
         .eng_hi   (eng_hi[c*(DW-HW) +: (DW-HW)]),
         .eng_lo   (eng_lo[c*LW +: LW]),
         .scount   (scount_o[c*DW +: DW]),
         .fadr     (fadr_o[c*DW +: DW]),
         .fcnt     (fcnt_o[c*DW +: DW]),
         .leftover (leftover_o[c*LW +: LW])
      );

      if (has_pause(c)) begin : g_pause
         assign run_en[c] = ctrl_q[en_bit(c)] && !sctl_q[pause_bit(c)];
      end else begin : g_nopause
         assign run_en[c] = ctrl_q[en_bit(c)];
      end
   end

   always_comb begin
      rd_mux = '1;
      if (fsel.ctrl)  rd_mux = ctrl_q;
      if (fsel.stat)  rd_mux = STAT_VAL;
      if (fsel.page)  rd_mux = {{(DW-PW){1'b0}}, page_q};
      if (fsel.codec) rd_mux = codec_r;
      if (fsel.sctl)  rd_mux = sctl_q;
      for (int c = 0; c < NCH; c++) begin
         if (s_scnt[c]) rd_mux = scount_o[c*DW +: DW];
         if (s_fadr[c]) rd_mux = fadr_o[c*DW +: DW];
         if (s_fcnt[c]) rd_mux = fcnt_o[c*DW +: DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/apc_regfile_chk.sv
module apc_regfile_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        rd_en,
   input logic [7:0]  addr,
   input logic [15:0] wd16,
   input logic [31:0] rdata,
   input logic        rvalid,
   input logic        ewe0,
   input logic [3:0]  page_q,
   input logic [31:0] sc0,
   input logic [1:0]  lo0
);
   a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);

   a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid);

   a_r3_page_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'h0C) |=> (page_q == $past(wd16[3:0])));

   a_r4_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 8'h04) |=> (rdata == 32'h0000_0060));

   a_r6_phantom_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && page_q == 4'hD && (addr == 8'h38 || addr == 8'h3C)) |=> (rdata == 32'hFFFF_FFFF));

   a_r7_scount_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'h24 && !ewe0) |=>
         (sc0[31:16] == $past(sc0[31:16]) && sc0[15:0] == $past(wd16)));

   a_r8_fcnt_clears_leftover: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'h34 && page_q == 4'hC) |=> (lo0 == 2'b00));
endmodule

bind apc_regfile apc_regfile_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .rd_en  (rd_en),
   .addr   (addr),
   .wd16   (wdata[15:0]),
   .rdata  (rdata),
   .rvalid (rvalid),
   .ewe0   (eng_we[0]),
   .page_q (page_q),
   .sc0    (scount_o[31:0]),
   .lo0    (leftover_o[1:0])
);

// File: tb/apc_regfile_tb_top.sv
module apc_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [2:0]  eng_we = '0;
   logic [47:0] eng_hi = '0;
   logic [5:0]  eng_lo = '0;
   logic [31:0] rdata, ctrl_q, sctl_q;
   logic        rvalid;
   logic [3:0]  page_q;
   logic [95:0] scount_o, fadr_o, fcnt_o;
   logic [5:0]  leftover_o;
   logic [2:0]  run_en;

   int n_cmp = 0, n_err = 0;
   bit cmp_on = 0;

   always #5 clk = ~clk;

   apc_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .eng_we(eng_we),
      .eng_hi(eng_hi), .eng_lo(eng_lo), .ctrl_q(ctrl_q), .sctl_q(sctl_q),
      .page_q(page_q), .scount_o(scount_o), .fadr_o(fadr_o), .fcnt_o(fcnt_o),
      .leftover_o(leftover_o), .run_en(run_en)
   );

   // reference model
   logic [31:0] m_ctrl, m_sctl, m_codec, m_rd;
   logic [3:0]  m_page;
   logic [31:0] m_sc[3], m_fa[3], m_fc[3];
   logic [1:0]  m_lo[3];
   logic        m_rv;

   function automatic logic [11:0] m_ia(input logic [7:0] a);
      if (a >= 8'h30 && a <= 8'h3F) return {m_page, a};
      return {4'h0, a};
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (m_ia(a))
         12'h000: return m_ctrl;
         12'h004: return 32'h0000_0060;
         12'h00C: return {28'h0, m_page};
         12'h010: return m_codec;
         12'h020: return m_sctl;
         12'h024: return m_sc[0];
         12'h028: return m_sc[1];
         12'h02C: return m_sc[2];
         12'hC30: return m_fa[0];
         12'hC34: return m_fc[0];
         12'hC38: return m_fa[1];
         12'hC3C: return m_fc[1];
         12'hD30: return m_fa[2];
         12'hD34: return m_fc[2];
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 32'h1; m_sctl = 0; m_codec = 0; m_page = 0; m_rd = 0; m_rv = 0;
         for (int c = 0; c < 3; c++) begin m_sc[c] = 0; m_fa[c] = 0; m_fc[c] = 0; m_lo[c] = 0; end
      end else begin
         logic [11:0] ia;
         ia = m_ia(addr);
         m_rv = rd_en;
         if (rd_en) m_rd = m_read(addr);
         for (int c = 0; c < 3; c++)
            if (eng_we[c]) begin m_sc[c][31:16] = eng_hi[c*16 +: 16]; m_lo[c] = eng_lo[c*2 +: 2]; end
         if (wr_en) begin
            case (ia)
               12'h000: m_ctrl = wdata;
               12'h00C: m_page = wdata[3:0];
               12'h010: m_codec = wdata;
               12'h020: m_sctl = wdata;
               12'h024: m_sc[0][15:0] = wdata[15:0];
               12'h028: m_sc[1][15:0] = wdata[15:0];
               12'h02C: m_sc[2][15:0] = wdata[15:0];
               12'hC30: m_fa[0] = wdata;
               12'hC34: begin m_fc[0] = wdata; m_lo[0] = 0; end
               12'hC38: m_fa[1] = wdata;
               12'hC3C: begin m_fc[1] = wdata; m_lo[1] = 0; end
               12'hD30: m_fa[2] = wdata;
               12'hD34: begin m_fc[2] = wdata; m_lo[2] = 0; end
               default: ;
            endcase
         end
      end
   end

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         cmp("R4 ctrl", ctrl_q, m_ctrl);
         cmp("R4 sctl", sctl_q, m_sctl);
         cmp("R3 page", {28'h0, page_q}, {28'h0, m_page});
         cmp("R2 rvalid", {31'h0, rvalid}, {31'h0, m_rv});
         if (m_rv) cmp("R2 rdata", rdata, m_rd);
         for (int c = 0; c < 3; c++) begin
            cmp("R7 scount", scount_o[c*32 +: 32], m_sc[c]);
            cmp("R5 fadr", fadr_o[c*32 +: 32], m_fa[c]);
            cmp("R5 fcnt", fcnt_o[c*32 +: 32], m_fc[c]);
            cmp("R8 leftover", {30'h0, leftover_o[c*2 +: 2]}, {30'h0, m_lo[c]});
         end
         cmp("R10 run_en", {29'h0, run_en},
             {29'h0, m_ctrl[4], m_ctrl[5] & ~m_sctl[12], m_ctrl[6] & ~m_sctl[11]});
      end
   end

   task automatic op(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d,
                     input logic [2:0] ewe, input logic [47:0] ehi, input logic [5:0] elo);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; eng_we = ewe; eng_hi = ehi; eng_lo = elo;
      @(negedge clk);
      wr_en = 0; rd_en = 0; eng_we = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      op(1, 0, a, d, 3'b0, 48'h0, 6'h0);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      op(0, 1, a, 32'h0, 3'b0, 48'h0, 6'h0);
      cmp(tag, rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin
      logic [7:0] pool[16];
      pool = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h20, 8'h24, 8'h28, 8'h2C,
               8'h30, 8'h34, 8'h38, 8'h3C, 8'h08, 8'h22, 8'h40, 8'hFC};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset values
      cmp("R1 ctrl", ctrl_q, 32'h1);
      cmp("R1 rvalid", {31'h0, rvalid}, 32'h0);
      cmp("R1 scount", scount_o[31:0], 32'h0);
      cmp_on = 1;
      rd_chk("R1 status", 8'h04, 32'h60);
      rd_chk("R1 codec", 8'h10, 32'h0);
      // R4 status ignores writes, codec/ctrl writable
      wr(8'h04, 32'h1234_5678);
      rd_chk("R4 status", 8'h04, 32'h60);
      wr(8'h10, 32'hCAFE_F00D);
      rd_chk("R4 codec", 8'h10, 32'hCAFE_F00D);
      // R3 page stores low bits only
      wr(8'h0C, 32'hFFFF_FFFC);
      rd_chk("R3 page", 8'h0C, 32'hC);
      // R5 paged frame regs
      wr(8'h30, 32'hAAAA_0001);
      wr(8'h3C, 32'hBBBB_0002);
      rd_chk("R5 pb1 fadr", 8'h30, 32'hAAAA_0001);
      wr(8'h0C, 32'hD);
      wr(8'h34, 32'hCCCC_0003);
      rd_chk("R5 cap fcnt", 8'h34, 32'hCCCC_0003);
      // R6 phantom and undecoded
      wr(8'h38, 32'h0);
      rd_chk("R6 phantom", 8'h38, 32'hFFFF_FFFF);
      rd_chk("R6 misaligned", 8'h22, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h3);
      rd_chk("R6 unused page", 8'h30, 32'hFFFF_FFFF);
      // R9 engine update, then R7 host write keeps upper half
      op(0, 0, 8'h00, 32'h0, 3'b001, 48'h0000_0000_5A5A, 6'h3);
      cmp("R9 eng scount hi", scount_o[31:0], 32'h5A5A_0000);
      wr(8'h24, 32'hFFFF_1234);
      rd_chk("R7 scount", 8'h24, 32'h5A5A_1234);
      // R8 frame-count write beats engine leftover load
      wr(8'h0C, 32'hC);
      op(1, 0, 8'h34, 32'h7, 3'b001, 48'h1, 6'h2);
      cmp("R8 leftover", {30'h0, leftover_o[1:0]}, 32'h0);
      // R2 read sees pre-write state
      op(1, 1, 8'h20, 32'h0000_1840, 3'b0, 48'h0, 6'h0);
      cmp("R2 read-before-write", rdata, 32'h0);
      // R10 run enables
      wr(8'h00, 32'h70);
      cmp("R10 run", {29'h0, run_en}, 32'h4);
      wr(8'h20, 32'h0);
      cmp("R10 run all", {29'h0, run_en}, 32'h7);
      // mixed traffic
      for (int i = 0; i < 600; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = pool[$urandom_range(15)];
         d = $urandom;
         if (a == 8'h0C) d[3:0] = ($urandom_range(3) == 0) ? 4'($urandom) : ($urandom_range(1) ? 4'hC : 4'hD);
         op($urandom_range(1), $urandom_range(1), a, d, 3'($urandom), {$urandom, 16'($urandom)}, 6'($urandom));
      end
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule